// File: doc/BRIEF.md
# Core Step Sequencing Controller

This block is the control state machine of a single-issue, in-order processor core. It decides, on every clock edge, whether the core steps instructions, waits on an instruction-cache or data-cache miss, resumes after a miss, sleeps, or hands control to another core. The caches, decoder, datapath and trap logic stay outside the block. The block sees them only through per-step flags (fetch miss, data miss, data read, fault) and two completion strobes.

Up to WIDTH instruction steps are taken per clock. Steps are taken in lane order, and the walk stops at the first step that leaves the running state or faults. Each step that completes moves the program counter forward by one 32-bit word. A fetch miss resumes into a held state, so the instruction already fetched is not fetched again. A request to switch out that arrives during a data miss is parked until that miss completes. Each cache has a saturating stall counter that measures the cycles the core spent waiting on it.

Top module: `core_step_ctrl`

## Requirements
- R1: A synchronous reset has the following effects. The state becomes idle, the program counter takes RESET_PC, both stall counters are zero, the error flag is clear, and all pulse outputs are low.
- R2: The state codes are: idle 0, running 1, fetch-miss 2, fetch-held 3, data-miss 4, data-miss-switch 5, switched-out 6. Activate moves idle to running. Suspend moves running to idle. Either request in any other state is ignored, and a switch request overrides both.
- R3: In running or fetch-held, lanes 0 to WIDTH-1 are stepped in order on each edge. Every executed step adds 4 to the program counter. The exec count output shows how many steps executed on the last edge, and it never exceeds WIDTH.
- R4: The fetch address of lane k is the program counter plus 4k, with its two low bits cleared.
- R5: A fetch miss on a lane that is reached stops the walk without executing that step, and the state moves to fetch-miss. When the instruction cache completes, the state moves to fetch-held. On the next edge, lane 0 executes without looking at its fetch-miss flag, and the state returns to running.
- R6: A data miss on an executed step moves the state to data-miss. That step still counts and still advances the program counter. When the data cache completes, the state returns to running, and read-done pulses if that step was a read.
- R7: A fault on a reached lane that has no fetch miss pulses trap and stops the walk. The faulting step does not advance the program counter, and the state ends in running.
- R8: A switch request in data-miss moves the state to data-miss-switch, with no acknowledgement yet. A data completion there moves the state to switched-out, pulses the acknowledgement, and pulses read-done for a read. If the switch request and the completion arrive on the same edge in data-miss, the state goes straight to switched-out with the acknowledgement.
- R9: In idle, running, fetch-miss or fetch-held, a switch request moves the state to switched-out on that edge. No step is taken, and the acknowledgement pulses. Switched-out is final until reset. In switched-out, every input, including either completion, is ignored and raises no error.
- R10: The fetch stall counter grows by one on each edge that finds the state in fetch-miss. The data stall counter grows by one on each edge that finds the state in data-miss. Both counters hold at their all-ones value.
- R11: A completion is unexpected when it arrives in a state that awaits none from that cache. For the instruction cache, that is any state other than fetch-miss and switched-out. For the data cache, that is any state other than data-miss, data-miss-switch and switched-out. An unexpected completion sets a sticky error flag and does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| activate_i | input | 1 | Request to leave idle |
| suspend_i | input | 1 | Suspend, halt or release request |
| switch_req_i | input | 1 | Request to hand control to another core |
| imiss_i | input | WIDTH | Per-lane fetch miss |
| dmiss_i | input | WIDTH | Per-lane data miss |
| dread_i | input | WIDTH | Per-lane flag: data access is a read |
| fault_i | input | WIDTH | Per-lane fault |
| icache_done_i | input | 1 | Instruction-cache miss completion |
| dcache_done_i | input | 1 | Data-cache miss completion |
| state_o | output | 3 | Current state code |
| pc_o | output | PC_W | Program counter |
| fetch_addr_o | output | WIDTH*PC_W | Word-aligned fetch address per lane, lane k at bits k*PC_W |
| exec_cnt_o | output | clog2(WIDTH+1) | Steps executed on the last edge |
| trap_o | output | 1 | Fault pulse |
| read_done_o | output | 1 | Pulse: a stalled read has finished |
| switched_o | output | 1 | Switched-out acknowledgement pulse |
| err_o | output | 1 | Sticky unexpected-completion flag |
| istall_o | output | CNT_W | Fetch stall cycles |
| dstall_o | output | CNT_W | Data stall cycles |

## Verification
The bench builds the block with WIDTH=3. This puts a miss or fault on a middle or last lane within reach, and it shows that the walk truncates mid-clock. CNT_W is set to 6, so a single 70-cycle fetch stall drives the counter into saturation. RESET_PC is 0x103, an unaligned value, so the low-bit clearing of the fetch address is visible on every lane.

// File: rtl/core_step_pkg.sv
package core_step_pkg;

  typedef enum logic [2:0] {
    CS_IDLE    = 3'd0,
    CS_RUN     = 3'd1,
    CS_IMISS   = 3'd2,
    CS_IHELD   = 3'd3,
    CS_DMISS   = 3'd4,
    CS_DSWITCH = 3'd5,
    CS_GONE    = 3'd6
  } core_state_e;

  // States in which an instruction-cache completion is expected or harmless
  function automatic logic iresp_allowed(core_state_e s);
    return (s == CS_IMISS) || (s == CS_GONE);
  endfunction

  // States in which a data-cache completion is expected or harmless
  function automatic logic dresp_allowed(core_state_e s);
    return (s == CS_DMISS) || (s == CS_DSWITCH) || (s == CS_GONE);
  endfunction

endpackage

// File: rtl/core_step_walk.sv
module core_step_walk
  import core_step_pkg::*;
#(
  parameter int WIDTH = 2,
  parameter int EW    = $clog2(WIDTH + 1)
) (
  input  core_state_e      cur_i,
  input  logic             go_i,
  input  logic [WIDTH-1:0] imiss_i,
  input  logic [WIDTH-1:0] dmiss_i,
  input  logic [WIDTH-1:0] dread_i,
  input  logic [WIDTH-1:0] fault_i,
  output core_state_e      nxt_o,
  output logic [EW-1:0]    exec_o,
  output logic             trap_o,
  output logic             dstall_o,
  output logic             dread_o
);

  logic stop;

  // Lane-ordered walk; the first lane that leaves running or faults ends it
  always_comb begin
    nxt_o    = go_i ? CS_RUN : cur_i;
    exec_o   = '0;
    trap_o   = 1'b0;
    dstall_o = 1'b0;
    dread_o  = 1'b0;
    stop     = !go_i;
    for (int k = 0; k < WIDTH; k++) begin
      if (!stop) begin
        if (!((k == 0) && (cur_i == CS_IHELD)) && imiss_i[k]) begin
          nxt_o = CS_IMISS;
          stop  = 1'b1;
        end else if (fault_i[k]) begin
          trap_o = 1'b1;
          stop   = 1'b1;
        end else begin
          exec_o = exec_o + EW'(1);
          if (dmiss_i[k]) begin
            nxt_o    = CS_DMISS;
            dstall_o = 1'b1;
            dread_o  = dread_i[k];
            stop     = 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/core_step_pc.sv
module core_step_pc #(
  parameter int               WIDTH    = 2,
  parameter int               PC_W     = 32,
  parameter int               EW       = $clog2(WIDTH + 1),
  parameter logic [PC_W-1:0]  RESET_PC = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [EW-1:0]         adv_i,
  output logic [PC_W-1:0]       pc_o,
  output logic [WIDTH*PC_W-1:0] fetch_addr_o
);

  function automatic logic [PC_W-1:0] pc_after(logic [PC_W-1:0] pc, logic [EW-1:0] n);
    return pc + (PC_W'(n) << 2);
  endfunction

  function automatic logic [PC_W-1:0] word_align(logic [PC_W-1:0] a);
    return {a[PC_W-1:2], 2'b00};
  endfunction

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_after(pc_q, adv_i);
  end

  assign pc_o = pc_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    assign fetch_addr_o[g*PC_W +: PC_W] = word_align(pc_q + PC_W'(4 * g));
  end

  // Whole-word steps never disturb the byte offset of the counter
  assert_pc_offset_R3: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pc_q[1:0] == $past(pc_q[1:0]));

  assert_pc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && adv_i == '0) |=> $stable(pc_q));

endmodule

// File: rtl/core_step_stall.sv
module core_step_stall #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] TOP = '1;

  function automatic logic [CNT_W-1:0] sat_bump(logic [CNT_W-1:0] v);
    return (v == TOP) ? v : v + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (en_i) cnt_q <= sat_bump(cnt_q);
  end

  assign cnt_o = cnt_q;

  assert_stall_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cnt_q >= $past(cnt_q));

  assert_stall_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!rst && !en_i) |=> $stable(cnt_q));

endmodule

// File: rtl/core_step_ctrl.sv
module core_step_ctrl
  import core_step_pkg::*;
#(
  parameter int              WIDTH    = 2,
  parameter int              PC_W     = 32,
  parameter int              CNT_W    = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int             EW       = $clog2(WIDTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  activate_i,
  input  logic                  suspend_i,
  input  logic                  switch_req_i,
  input  logic [WIDTH-1:0]      imiss_i,
  input  logic [WIDTH-1:0]      dmiss_i,
  input  logic [WIDTH-1:0]      dread_i,
  input  logic [WIDTH-1:0]      fault_i,
  input  logic                  icache_done_i,
  input  logic                  dcache_done_i,
  output logic [2:0]            state_o,
  output logic [PC_W-1:0]       pc_o,
  output logic [WIDTH*PC_W-1:0] fetch_addr_o,
  output logic [EW-1:0]         exec_cnt_o,
  output logic                  trap_o,
  output logic                  read_done_o,
  output logic                  switched_o,
  output logic                  err_o,
  output logic [CNT_W-1:0]      istall_o,
  output logic [CNT_W-1:0]      dstall_o
);

  core_state_e state_q, state_n;
  logic        pend_read_q, pend_read_n;
  logic        err_q, err_n;
  logic [EW-1:0] exec_n, exec_q;
  logic        trap_n, trap_q, rd_n, rd_q, ack_n, ack_q;

  // Named internal events
  logic        step_go;
  logic        bad_iresp, bad_dresp;
  core_state_e walk_nxt;
  logic [EW-1:0] walk_exec;
  logic        walk_trap, walk_dmiss, walk_dread;

  assign step_go   = !switch_req_i &&
                     ((state_q == CS_RUN && !suspend_i) || state_q == CS_IHELD);
  assign bad_iresp = icache_done_i && !iresp_allowed(state_q);
  assign bad_dresp = dcache_done_i && !dresp_allowed(state_q);

  core_step_walk #(.WIDTH(WIDTH), .EW(EW)) u_walk (
    .cur_i   (state_q),
    .go_i    (step_go),
    .imiss_i (imiss_i),
    .dmiss_i (dmiss_i),
    .dread_i (dread_i),
    .fault_i (fault_i),
    .nxt_o   (walk_nxt),
    .exec_o  (walk_exec),
    .trap_o  (walk_trap),
    .dstall_o(walk_dmiss),
    .dread_o (walk_dread)
  );

  always_comb begin
    state_n     = state_q;
    pend_read_n = pend_read_q;
    err_n       = err_q || bad_iresp || bad_dresp;
    exec_n      = '0;
    trap_n      = 1'b0;
    rd_n        = 1'b0;
    ack_n       = 1'b0;
    unique case (state_q)
      CS_GONE: ;
      CS_DSWITCH: begin
        if (dcache_done_i) begin
          rd_n    = pend_read_q;
          state_n = CS_GONE;
          ack_n   = 1'b1;
        end
      end
      CS_DMISS: begin
        if (dcache_done_i) begin
          rd_n = pend_read_q;
          if (switch_req_i) begin
            state_n = CS_GONE;
            ack_n   = 1'b1;
          end else begin
            state_n = CS_RUN;
          end
        end else if (switch_req_i) begin
          state_n = CS_DSWITCH;
        end
      end
      CS_IMISS: begin
        if (switch_req_i) begin
          state_n = CS_GONE;
          ack_n   = 1'b1;
        end else if (icache_done_i) begin
          state_n = CS_IHELD;
        end
      end
      CS_IDLE: begin
        if (switch_req_i) begin
          state_n = CS_GONE;
          ack_n   = 1'b1;
        end else if (activate_i) begin
          state_n = CS_RUN;
        end
      end
      CS_RUN, CS_IHELD: begin
        if (switch_req_i) begin
          state_n = CS_GONE;
          ack_n   = 1'b1;
        end else if (state_q == CS_RUN && suspend_i) begin
          state_n = CS_IDLE;
        end else begin
          state_n = walk_nxt;
          exec_n  = walk_exec;
          trap_n  = walk_trap;
          if (walk_dmiss) pend_read_n = walk_dread;
        end
      end
      default: state_n = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= CS_IDLE;
      pend_read_q <= 1'b0;
      err_q       <= 1'b0;
      exec_q      <= '0;
      trap_q      <= 1'b0;
      rd_q        <= 1'b0;
      ack_q       <= 1'b0;
    end else begin
      state_q     <= state_n;
      pend_read_q <= pend_read_n;
      err_q       <= err_n;
      exec_q      <= exec_n;
      trap_q      <= trap_n;
      rd_q        <= rd_n;
      ack_q       <= ack_n;
    end
  end

  core_step_pc #(.WIDTH(WIDTH), .PC_W(PC_W), .EW(EW), .RESET_PC(RESET_PC)) u_pc (
    .clk         (clk),
    .rst         (rst),
    .adv_i       (exec_n),
    .pc_o        (pc_o),
    .fetch_addr_o(fetch_addr_o)
  );

  logic [1:0]       stall_en;
  logic [CNT_W-1:0] stall_cnt [2];

  assign stall_en[0] = (state_q == CS_IMISS);
  assign stall_en[1] = (state_q == CS_DMISS);

  for (genvar g = 0; g < 2; g++) begin : g_stall
    core_step_stall #(.CNT_W(CNT_W)) u_ctr (
      .clk  (clk),
      .rst  (rst),
      .en_i (stall_en[g]),
      .cnt_o(stall_cnt[g])
    );
  end

  assign state_o     = state_q;
  assign exec_cnt_o  = exec_q;
  assign trap_o      = trap_q;
  assign read_done_o = rd_q;
  assign switched_o  = ack_q;
  assign err_o       = err_q;
  assign istall_o    = stall_cnt[0];
  assign dstall_o    = stall_cnt[1];

  assert_activate_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == CS_IDLE && activate_i && !switch_req_i) |=> state_q == CS_RUN);

  assert_exec_bound_R3: assert property (@(posedge clk) disable iff (rst)
    exec_cnt_o <= EW'(WIDTH));

  assert_held_once_R5: assert property (@(posedge clk) disable iff (rst)
    state_q == CS_IHELD |=> state_q != CS_IHELD);

  assert_read_done_src_R6: assert property (@(posedge clk) disable iff (rst)
    read_done_o |-> ($past(state_q) == CS_DMISS || $past(state_q) == CS_DSWITCH));

  assert_park_no_ack_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == CS_DMISS && switch_req_i && !dcache_done_i) |=>
      (state_q == CS_DSWITCH && !switched_o));

  assert_gone_final_R9: assert property (@(posedge clk) disable iff (rst)
    state_q == CS_GONE |=> state_q == CS_GONE);

  assert_ack_state_R9: assert property (@(posedge clk) disable iff (rst)
    switched_o |-> state_q == CS_GONE);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o);

endmodule

// File: tb/core_step_ctrl_bench.sv
module core_step_ctrl_bench;

  localparam int              W    = 3;
  localparam int              PW   = 32;
  localparam int              CW   = 6;
  localparam int              EW   = $clog2(W + 1);
  localparam logic [PW-1:0]   RPC  = 32'h0000_0103;
  localparam int              MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic activate_i = 0, suspend_i = 0, switch_req_i = 0;
  logic [W-1:0] imiss_i = '0, dmiss_i = '0, dread_i = '0, fault_i = '0;
  logic icache_done_i = 0, dcache_done_i = 0;
  logic [2:0] state_o;
  logic [PW-1:0] pc_o;
  logic [W*PW-1:0] fetch_addr_o;
  logic [EW-1:0] exec_cnt_o;
  logic trap_o, read_done_o, switched_o, err_o;
  logic [CW-1:0] istall_o, dstall_o;

  always #10 clk = ~clk;

  core_step_ctrl #(.WIDTH(W), .PC_W(PW), .CNT_W(CW), .RESET_PC(RPC)) u_core_step_ctrl (
    .clk, .rst, .activate_i, .suspend_i, .switch_req_i,
    .imiss_i, .dmiss_i, .dread_i, .fault_i, .icache_done_i, .dcache_done_i,
    .state_o, .pc_o, .fetch_addr_o, .exec_cnt_o, .trap_o, .read_done_o,
    .switched_o, .err_o, .istall_o, .dstall_o
  );

  int checks = 0;
  int errors = 0;

  // Reference state, from the requirements
  int ms, mi, md, mexec;
  logic [PW-1:0] mpc;
  bit merr, mpend, mtrap, mrd, mack;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] lane_addr(logic [PW-1:0] pc, int k);
    return (pc + PW'(4 * k)) & ~PW'(3);
  endfunction

  task automatic model_edge();
    bit stop;
    int nx;
    mexec = 0; mtrap = 0; mrd = 0; mack = 0;
    if (rst) begin
      ms = 0; mpc = RPC; mi = 0; md = 0; merr = 0; mpend = 0;
      return;
    end
    if (ms == 2 && mi < MAXC) mi++;
    if (ms == 4 && md < MAXC) md++;
    if (icache_done_i && !(ms == 2 || ms == 6)) merr = 1;
    if (dcache_done_i && !(ms == 4 || ms == 5 || ms == 6)) merr = 1;
    case (ms)
      5: if (dcache_done_i) begin mrd = mpend; ms = 6; mack = 1; end
      4: begin
        if (dcache_done_i) begin
          mrd = mpend;
          if (switch_req_i) begin ms = 6; mack = 1; end else ms = 1;
        end else if (switch_req_i) ms = 5;
      end
      2: begin
        if (switch_req_i) begin ms = 6; mack = 1; end
        else if (icache_done_i) ms = 3;
      end
      0: begin
        if (switch_req_i) begin ms = 6; mack = 1; end
        else if (activate_i) ms = 1;
      end
      1, 3: begin
        if (switch_req_i) begin ms = 6; mack = 1; end
        else if (ms == 1 && suspend_i) ms = 0;
        else begin
          stop = 0; nx = 1;
          for (int k = 0; k < W; k++) begin
            if (!stop) begin
              if (!(k == 0 && ms == 3) && imiss_i[k]) begin nx = 2; stop = 1; end
              else if (fault_i[k]) begin mtrap = 1; stop = 1; end
              else begin
                mexec++; mpc = mpc + 4;
                if (dmiss_i[k]) begin nx = 4; mpend = dread_i[k]; stop = 1; end
              end
            end
          end
          ms = nx;
        end
      end
      default: ;
    endcase
  endtask

  task automatic tick();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk("R2 state", 64'(state_o), 64'(ms));
    chk("R3 pc", 64'(pc_o), 64'(mpc));
    chk("R3 exec count", 64'(exec_cnt_o), 64'(mexec));
    for (int k = 0; k < W; k++)
      chk("R4 fetch address", 64'(fetch_addr_o[k*PW +: PW]), 64'(lane_addr(mpc, k)));
    chk("R7 trap", 64'(trap_o), 64'(mtrap));
    chk("R6 read done", 64'(read_done_o), 64'(mrd));
    chk("R9 switched ack", 64'(switched_o), 64'(mack));
    chk("R11 error flag", 64'(err_o), 64'(merr));
    chk("R10 fetch stall", 64'(istall_o), 64'(mi));
    chk("R10 data stall", 64'(dstall_o), 64'(md));
  endtask

  task automatic quiet();
    activate_i = 0; suspend_i = 0; switch_req_i = 0;
    imiss_i = '0; dmiss_i = '0; dread_i = '0; fault_i = '0;
    icache_done_i = 0; dcache_done_i = 0;
  endtask

  task automatic do_reset();
    quiet(); rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic rand_inputs();
    activate_i    = ($urandom % 4) == 0;
    suspend_i     = ($urandom % 24) == 0;
    switch_req_i  = ($urandom % 150) == 0;
    icache_done_i = ($urandom % 4) == 0;
    dcache_done_i = ($urandom % 4) == 0;
    for (int k = 0; k < W; k++) begin
      imiss_i[k] = ($urandom % 8) == 0;
      dmiss_i[k] = ($urandom % 8) == 0;
      dread_i[k] = ($urandom % 2) == 0;
      fault_i[k] = ($urandom % 16) == 0;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 reset state", 64'(state_o), 64'd0);
    chk("R1 reset pc", 64'(pc_o), 64'h103);
    chk("R1 reset stall", 64'(istall_o), 64'd0);
    chk("R1 reset err", 64'(err_o), 64'd0);
    chk("R4 lane0 aligned", 64'(fetch_addr_o[0 +: PW]), 64'h100);

    // R11: unexpected data completion in idle
    dcache_done_i = 1; tick(); quiet();
    chk("R11 err set in idle", 64'(err_o), 64'd1);
    chk("R11 state unchanged", 64'(state_o), 64'd0);
    tick();
    chk("R11 err sticky", 64'(err_o), 64'd1);

    // R5: fetch miss on lane 1, resume without refetch
    do_reset();
    activate_i = 1; tick(); quiet();
    tick();
    chk("R3 full width", 64'(exec_cnt_o), 64'd3);
    chk("R3 pc after three", 64'(pc_o), 64'h10F);
    imiss_i = 3'b010; tick(); quiet();
    chk("R5 miss lane1 exec", 64'(exec_cnt_o), 64'd1);
    chk("R5 enters fetch-miss", 64'(state_o), 64'd2);
    tick(); tick();
    icache_done_i = 1; tick(); quiet();
    chk("R5 held state", 64'(state_o), 64'd3);
    chk("R10 fetch stall three", 64'(istall_o), 64'd3);
    imiss_i = 3'b001; tick(); quiet();
    chk("R5 held lane executes", 64'(exec_cnt_o), 64'd3);
    chk("R5 back to running", 64'(state_o), 64'd1);
    chk("R5 pc", 64'(pc_o), 64'h11F);

    // R7: fault on lane 0
    fault_i = 3'b001; tick(); quiet();
    chk("R7 trap pulse", 64'(trap_o), 64'd1);
    chk("R7 pc held", 64'(pc_o), 64'h11F);

    // R8: parked switch during data read miss
    dmiss_i = 3'b001; dread_i = 3'b001; tick(); quiet();
    chk("R6 data miss state", 64'(state_o), 64'd4);
    switch_req_i = 1; tick(); quiet();
    chk("R8 parked", 64'(state_o), 64'd5);
    chk("R8 no ack yet", 64'(switched_o), 64'd0);
    dcache_done_i = 1; tick(); quiet();
    chk("R8 switched", 64'(state_o), 64'd6);
    chk("R8 ack", 64'(switched_o), 64'd1);
    chk("R8 read done", 64'(read_done_o), 64'd1);
    dcache_done_i = 1; icache_done_i = 1; activate_i = 1; tick(); quiet();
    chk("R9 ignored in switched-out", 64'(err_o), 64'd0);
    chk("R9 stays switched-out", 64'(state_o), 64'd6);

    // R10 saturation
    do_reset();
    activate_i = 1; tick(); quiet();
    imiss_i = 3'b001; tick(); quiet();
    repeat (70) tick();
    chk("R10 saturated", 64'(istall_o), 64'(MAXC));

    // Constrained random epochs
    for (int e = 0; e < 8; e++) begin
      do_reset();
      for (int c = 0; c < 400; c++) begin
        rand_inputs();
        tick();
      end
    end
    quiet();
    finish_run();
  end

endmodule